// File: doc/BRIEF.md
# SMBus Target Read Completion Record Writer

This block sits behind an SMBus slave engine and turns each finished read by an external master into a record in host memory. It accepts a completion event carrying the number of bytes moved and three error flags. It may write a header word into a ring of 32-bit words at the hardware head pointer, and then it moves that pointer on by one word, whether or not a header was written. It then publishes two interrupt-information words at separately programmed addresses. The first is a snapshot of the new head pointer. The second is an error word, written only when the read ended with an error. Last, it raises a one-cycle message-signalled interrupt request if interrupts are enabled.

The memory write port is valid/ready. Once `mw_valid` is high it stays high, with address and data unchanged, until a cycle in which `mw_ready` is high; the word is taken at that clock edge. The sequencer waits in each write step for as long as the memory holds ready low. The event input has no ready: the sequencer takes an event only when it is idle and ignores `evt_valid` in every other cycle. All addresses are word addresses. The pointer is held as an offset from `cfg_ring_base`, and that offset resets to zero.

Top module: `smb_cmpl_writer`

## Requirements
- R1: While reset is asserted, and in the first idle cycle after it, `mw_valid` and `irq_pulse` are low.
- R2: A completion without error (`evt_err` = 0) taken while `cfg_hdr_on_ok` = 1 writes a header word first, at `cfg_ring_base` + pointer offset. Its data is byte count in bits [7:0], error flags in bits [10:8], bit 31 = 1 and all other bits 0.
- R3: A completion without error taken while `cfg_hdr_on_ok` = 0 writes no header word. The pointer still advances, and the first write is the snapshot.
- R4: A completion with any error flag set always writes the header word, whatever `cfg_hdr_on_ok` holds, with the flags in bits [10:8]. The flag encoding is bit 0 = buffer almost full, bit 1 = buffer full, bit 2 = clock-low timeout.
- R5: On every completion the pointer offset advances by one. From offset `cfg_ring_words`-1 it wraps to 0, so the address after base+words-1 is base.
- R6: After the header step and the pointer advance, a snapshot word is written to `cfg_snap_addr`. Its data is the advanced head address in bits [AW-1:0], bit 31 = 1 and all other bits 0.
- R7: Only when the completion carries an error, an error word is written to `cfg_err_addr` after the snapshot. Its data is the flags in bits [2:0], bit 31 = 1 and all other bits 0.
- R8: `irq_pulse` is high for exactly one cycle, after the last write of a completion has been accepted, and only if `cfg_irq_en` = 1. With `cfg_irq_en` = 0 no pulse occurs.
- R9: While `mw_valid` is high and `mw_ready` is low, `mw_valid`, `mw_addr` and `mw_data` hold their values into the next cycle. Back-pressure delays the writes but does not change them.
- R10: `evt_valid` is ignored in every cycle in which a completion is already being processed, up to and including the cycle in which `irq_pulse` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | Completion event strobe from the slave engine |
| evt_bcnt | input | 8 | Bytes transferred in the finished read |
| evt_err | input | 3 | Error flags: [0] almost full, [1] full, [2] clock-low timeout |
| cfg_ring_base | input | AW | Word address of the first ring entry |
| cfg_ring_words | input | AW | Ring size in words |
| cfg_hdr_on_ok | input | 1 | Write a header on error-free completions too |
| cfg_snap_addr | input | AW | Word address of the head-pointer snapshot |
| cfg_err_addr | input | AW | Word address of the error word |
| cfg_irq_en | input | 1 | Enable the interrupt pulse |
| mw_valid | output | 1 | Memory write request |
| mw_ready | input | 1 | Memory accepts the write this cycle |
| mw_addr | output | AW | Memory write word address |
| mw_data | output | 32 | Memory write data |
| irq_pulse | output | 1 | One-cycle interrupt request |

## Verification
Two things can land on the same clock edge: a new completion event, and the last busy cycle of the previous completion, which is the interrupt cycle. The bench raises `evt_valid` and holds it high through the whole sequence, including the edge that ends the `irq_pulse` cycle, and lowers it only in the idle cycle that follows. The result counts as correct only if memory receives exactly one header and one snapshot and only one interrupt pulse occurs, with nothing more in the following forty cycles.

// File: rtl/smb_cmpl_pkg.sv
package smb_cmpl_pkg;

  localparam int BC_W    = 8;
  localparam int ERR_W   = 3;
  localparam int WORD_W  = 32;
  localparam int VLD_BIT = 31;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_HDR  = 3'd1,
    ST_ADV  = 3'd2,
    ST_SNAP = 3'd3,
    ST_ERRW = 3'd4,
    ST_IRQ  = 3'd5
  } seq_st_t;

  function automatic logic [WORD_W-1:0] pack_hdr(input logic [BC_W-1:0] bc,
                                                 input logic [ERR_W-1:0] er);
    logic [WORD_W-1:0] w;
    w = '0;
    w[BC_W-1:0] = bc;
    w[BC_W+ERR_W-1:BC_W] = er;
    w[VLD_BIT] = 1'b1;
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] pack_err(input logic [ERR_W-1:0] er);
    logic [WORD_W-1:0] w;
    w = '0;
    w[ERR_W-1:0] = er;
    w[VLD_BIT] = 1'b1;
    return w;
  endfunction

endpackage

// File: rtl/smb_cmpl_seq.sv
module smb_cmpl_seq
  import smb_cmpl_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    evt_valid,
  input  logic    evt_err_any,
  input  logic    lat_err_any,
  input  logic    hdr_on_ok,
  input  logic    wr_ready,
  output seq_st_t state,
  output logic    accept,
  output logic    adv
);

  seq_st_t nxt;

  assign accept = (state == ST_IDLE) && evt_valid;
  assign adv    = (state == ST_ADV);

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE: if (evt_valid) nxt = (evt_err_any || hdr_on_ok) ? ST_HDR : ST_ADV;
      ST_HDR:  if (wr_ready) nxt = ST_ADV;
      ST_ADV:  nxt = ST_SNAP;
      ST_SNAP: if (wr_ready) nxt = lat_err_any ? ST_ERRW : ST_IRQ;
      ST_ERRW: if (wr_ready) nxt = ST_IRQ;
      ST_IRQ:  nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

endmodule

// File: rtl/smb_ring_ptr.sv
module smb_ring_ptr #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] words,
  input  logic          adv,
  output logic [AW-1:0] off,
  output logic [AW-1:0] head
);

  logic [AW:0] off_inc;

  assign off_inc = {1'b0, off} + {{AW{1'b0}}, 1'b1};
  assign head    = base + off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off <= '0;
    end else if (adv) begin
      if (off_inc >= {1'b0, words}) off <= '0;
      else                          off <= off_inc[AW-1:0];
    end
  end

endmodule

// File: rtl/smb_word_fmt.sv
module smb_word_fmt
  import smb_cmpl_pkg::*;
#(
  parameter int AW = 16
) (
  input  seq_st_t             state,
  input  logic [AW-1:0]       head,
  input  logic [AW-1:0]       snap_addr,
  input  logic [AW-1:0]       err_addr,
  input  logic [BC_W-1:0]     bcnt,
  input  logic [ERR_W-1:0]    err,
  output logic                wr_valid,
  output logic [AW-1:0]       wr_addr,
  output logic [WORD_W-1:0]   wr_data
);

  logic [WORD_W-1:0] snap_w;

  always_comb begin
    snap_w = WORD_W'(head);
    snap_w[VLD_BIT] = 1'b1;
  end

  always_comb begin
    wr_valid = 1'b0;
    wr_addr  = '0;
    wr_data  = '0;
    case (state)
      ST_HDR: begin
        wr_valid = 1'b1;
        wr_addr  = head;
        wr_data  = pack_hdr(bcnt, err);
      end
      ST_SNAP: begin
        wr_valid = 1'b1;
        wr_addr  = snap_addr;
        wr_data  = snap_w;
      end
      ST_ERRW: begin
        wr_valid = 1'b1;
        wr_addr  = err_addr;
        wr_data  = pack_err(err);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/smb_cmpl_writer.sv
module smb_cmpl_writer
  import smb_cmpl_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               evt_valid,
  input  logic [BC_W-1:0]    evt_bcnt,
  input  logic [ERR_W-1:0]   evt_err,
  input  logic [AW-1:0]      cfg_ring_base,
  input  logic [AW-1:0]      cfg_ring_words,
  input  logic               cfg_hdr_on_ok,
  input  logic [AW-1:0]      cfg_snap_addr,
  input  logic [AW-1:0]      cfg_err_addr,
  input  logic               cfg_irq_en,
  output logic               mw_valid,
  input  logic               mw_ready,
  output logic [AW-1:0]      mw_addr,
  output logic [WORD_W-1:0]  mw_data,
  output logic               irq_pulse
);

  seq_st_t           state;
  logic              accept;
  logic              adv;
  logic [BC_W-1:0]   lat_bcnt;
  logic [ERR_W-1:0]  lat_err;
  logic [AW-1:0]     head_off;
  logic [AW-1:0]     head_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_bcnt <= '0;
      lat_err  <= '0;
    end else if (accept) begin
      lat_bcnt <= evt_bcnt;
      lat_err  <= evt_err;
    end
  end

  smb_cmpl_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_valid   (evt_valid),
    .evt_err_any (|evt_err),
    .lat_err_any (|lat_err),
    .hdr_on_ok   (cfg_hdr_on_ok),
    .wr_ready    (mw_ready),
    .state       (state),
    .accept      (accept),
    .adv         (adv)
  );

  smb_ring_ptr #(.AW(AW)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .base  (cfg_ring_base),
    .words (cfg_ring_words),
    .adv   (adv),
    .off   (head_off),
    .head  (head_addr)
  );

  smb_word_fmt #(.AW(AW)) u_fmt (
    .state     (state),
    .head      (head_addr),
    .snap_addr (cfg_snap_addr),
    .err_addr  (cfg_err_addr),
    .bcnt      (lat_bcnt),
    .err       (lat_err),
    .wr_valid  (mw_valid),
    .wr_addr   (mw_addr),
    .wr_data   (mw_data)
  );

  assign irq_pulse = (state == ST_IRQ) && cfg_irq_en;

endmodule

// File: rtl/smb_cmpl_writer_chk.sv
module smb_cmpl_writer_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mw_valid,
  input logic          mw_ready,
  input logic [AW-1:0] mw_addr,
  input logic [31:0]   mw_data,
  input logic          irq_pulse,
  input logic          cfg_irq_en,
  input logic [AW-1:0] head_off,
  input logic [AW-1:0] cfg_ring_words
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      assert_quiet_in_reset_R1: assert (!mw_valid && !irq_pulse)
        else $error("R1: outputs active during reset");
    end
  end

  assert_hold_under_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_valid && !mw_ready) |=> (mw_valid && $stable(mw_addr) && $stable(mw_data)));

  assert_irq_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);

  assert_irq_after_writes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> (!mw_valid && cfg_irq_en));

  assert_irq_follows_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pulse) |-> $past(!mw_valid || mw_ready));

  assert_ptr_in_ring_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ring_words > 1) |-> (head_off < cfg_ring_words));

endmodule

bind smb_cmpl_writer smb_cmpl_writer_chk #(.AW(AW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .mw_valid       (mw_valid),
  .mw_ready       (mw_ready),
  .mw_addr        (mw_addr),
  .mw_data        (mw_data),
  .irq_pulse      (irq_pulse),
  .cfg_irq_en     (cfg_irq_en),
  .head_off       (head_off),
  .cfg_ring_words (cfg_ring_words)
);

// File: tb/smb_cmpl_writer_tb_top.sv
`timescale 1ns/1ps
module smb_cmpl_writer_tb_top;

  localparam int AW = 16;
  localparam logic [AW-1:0] BASE  = 16'h0100;
  localparam logic [AW-1:0] WORDS = 16'd4;
  localparam logic [AW-1:0] SNAPA = 16'h0800;
  localparam logic [AW-1:0] ERRA  = 16'h0801;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          evt_valid = 1'b0;
  logic [7:0]    evt_bcnt = '0;
  logic [2:0]    evt_err = '0;
  logic          cfg_hdr_on_ok = 1'b1;
  logic          cfg_irq_en = 1'b1;
  logic          mw_valid;
  logic          mw_ready;
  logic [AW-1:0] mw_addr;
  logic [31:0]   mw_data;
  logic          irq_pulse;
  logic          stall_en = 1'b0;

  always #5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  int cyc   = 0;
  int log_n = 0;
  int irq_n = 0;
  int irq_cyc = 0;
  int last_wr_cyc = 0;
  int stall_cycles = 0;
  logic [AW-1:0] log_addr [64];
  logic [31:0]   log_data [64];
  logic [AW-1:0] exp_off = '0;

  assign mw_ready = !stall_en || (cyc % 4 == 3);

  smb_cmpl_writer #(.AW(AW)) dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .evt_valid      (evt_valid),
    .evt_bcnt       (evt_bcnt),
    .evt_err        (evt_err),
    .cfg_ring_base  (BASE),
    .cfg_ring_words (WORDS),
    .cfg_hdr_on_ok  (cfg_hdr_on_ok),
    .cfg_snap_addr  (SNAPA),
    .cfg_err_addr   (ERRA),
    .cfg_irq_en     (cfg_irq_en),
    .mw_valid       (mw_valid),
    .mw_ready       (mw_ready),
    .mw_addr        (mw_addr),
    .mw_data        (mw_data),
    .irq_pulse      (irq_pulse)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && mw_valid && mw_ready) begin
      log_addr[log_n % 64] <= mw_addr;
      log_data[log_n % 64] <= mw_data;
      log_n <= log_n + 1;
      last_wr_cyc <= cyc;
    end
    if (rst_n && mw_valid && !mw_ready) stall_cycles <= stall_cycles + 1;
    if (irq_pulse) begin
      irq_n <= irq_n + 1;
      irq_cyc <= cyc;
    end
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] hdr_w(input logic [7:0] b, input logic [2:0] e);
    return {1'b1, 20'd0, e, b};
  endfunction

  function automatic logic [31:0] snap_w(input logic [AW-1:0] a);
    return {1'b1, 15'd0, a};
  endfunction

  function automatic logic [AW-1:0] next_off(input logic [AW-1:0] o);
    return (o == WORDS - 1) ? '0 : o + 1'b1;
  endfunction

  task automatic fire(input logic [7:0] b, input logic [2:0] e);
    @(negedge clk);
    evt_valid = 1'b1; evt_bcnt = b; evt_err = e;
    @(negedge clk);
    evt_valid = 1'b0;
    repeat (40) @(negedge clk);
  endtask

  // Runs one completion and checks every write it produces.
  task automatic run_and_check(input string rq, input logic [7:0] b, input logic [2:0] e);
    int s;
    int k;
    int irq0;
    bit hdr;
    logic [AW-1:0] hdr_a;
    s = log_n; irq0 = irq_n; k = s;
    hdr = (e != 3'b000) || cfg_hdr_on_ok;
    hdr_a = BASE + exp_off;
    exp_off = next_off(exp_off);
    fire(b, e);
    chk({rq, " write count"}, log_n - s, 1 + (hdr ? 1 : 0) + ((e != 0) ? 1 : 0));
    if (hdr) begin
      chk({rq, " R2/R4 header addr"}, 32'(log_addr[k % 64]), 32'(hdr_a));
      chk({rq, " R2/R4 header data"}, log_data[k % 64], hdr_w(b, e));
      k++;
    end
    chk({rq, " R6 snapshot addr"}, 32'(log_addr[k % 64]), 32'(SNAPA));
    chk({rq, " R5 R6 snapshot data"}, log_data[k % 64], snap_w(BASE + exp_off));
    k++;
    if (e != 0) begin
      chk({rq, " R7 error addr"}, 32'(log_addr[k % 64]), 32'(ERRA));
      chk({rq, " R7 error data"}, log_data[k % 64], {1'b1, 28'd0, e});
    end
    chk({rq, " R8 irq count"}, irq_n - irq0, cfg_irq_en ? 1 : 0);
    if (cfg_irq_en) chk({rq, " R8 irq after last write"}, 32'(irq_cyc > last_wr_cyc), 1);
  endtask

  task automatic t_reset();
    chk("R1 mw_valid in reset", 32'(mw_valid), 0);
    chk("R1 irq in reset", 32'(irq_pulse), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 mw_valid idle", 32'(mw_valid), 0);
    chk("R1 irq idle", 32'(irq_pulse), 0);
  endtask

  task automatic t_ok_hdr();
    cfg_hdr_on_ok = 1'b1;
    run_and_check("R2 ok+hdr", 8'h21, 3'b000);
  endtask

  task automatic t_ok_nohdr();
    cfg_hdr_on_ok = 1'b0;
    run_and_check("R3 ok no-hdr", 8'h05, 3'b000);
  endtask

  task automatic t_err();
    cfg_hdr_on_ok = 1'b0;
    run_and_check("R4 R7 err almost-full", 8'h10, 3'b001);
    run_and_check("R4 R7 err full", 8'h7f, 3'b010);
    cfg_hdr_on_ok = 1'b1;
    run_and_check("R4 R7 err timeout", 8'h02, 3'b100);
  endtask

  task automatic t_wrap();
    cfg_hdr_on_ok = 1'b1;
    for (int i = 0; i < 5; i++) run_and_check("R5 wrap", 8'(i + 1), 3'b000);
  endtask

  task automatic t_backpressure();
    int s0;
    s0 = stall_cycles;
    stall_en = 1'b1;
    cfg_hdr_on_ok = 1'b1;
    run_and_check("R9 stalled", 8'hc3, 3'b011);
    chk("R9 stall seen", 32'(stall_cycles > s0), 1);
    stall_en = 1'b0;
  endtask

  task automatic t_irq_off();
    cfg_irq_en = 1'b0;
    run_and_check("R8 irq disabled", 8'h44, 3'b000);
    cfg_irq_en = 1'b1;
  endtask

  task automatic t_busy_ignore();
    int s;
    int irq0;
    bit seen;
    logic [AW-1:0] hdr_a;
    s = log_n; irq0 = irq_n; seen = 1'b0;
    cfg_hdr_on_ok = 1'b1; cfg_irq_en = 1'b1;
    hdr_a = BASE + exp_off;
    exp_off = next_off(exp_off);
    @(negedge clk);
    evt_valid = 1'b1; evt_bcnt = 8'h11; evt_err = 3'b000;
    for (int i = 0; i < 60 && !seen; i++) begin
      @(negedge clk);
      if (irq_pulse) seen = 1'b1;
    end
    @(negedge clk);
    evt_valid = 1'b0;
    repeat (40) @(negedge clk);
    chk("R10 irq seen", 32'(seen), 1);
    chk("R10 writes for held event", log_n - s, 2);
    chk("R10 irq count", irq_n - irq0, 1);
    chk("R10 header addr", 32'(log_addr[s % 64]), 32'(hdr_a));
    chk("R10 snapshot data", log_data[(s + 1) % 64], snap_w(BASE + exp_off));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_ok_hdr();
    t_ok_nohdr();
    t_err();
    t_wrap();
    t_backpressure();
    t_irq_off();
    t_busy_ignore();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule